// File: doc/BRIEF.md
# Link Power-State Controller for a Two-Port Signal-Conditioning Switch

This block is the control state machine of a two-port SuperSpeed signal-conditioning switch. It works out the link's power state from electrical evidence alone. That evidence is a signal-present flag for each direction, the result of a far-end termination probe, the port select and a supply-valid flag. It never decodes link power-management packets. From that evidence it enables the line drivers and equalizers of the chosen port, keeps the signal-present and probe circuits alive, asks for termination probes, and parks the port that is not chosen.

There are five internal states. Off means no supply. Probe means a termination detection is running. No-link saving means no far-end receiver was found. Idle saving means a receiver is present and the link is electrically idle. Active means the full datapath is on. A free-running prescaler makes microsecond and millisecond ticks. A single millisecond timer measures both the idle wait and the interval between probe retries. A change of the port select always starts a fresh probe.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `supply_ok` is low, or after reset, `pwr_state` is 0 (Off) and `drv_en`, `park`, `sq_en`, `det_req` and `term_ok` are all zero. When `supply_ok` falls in any state, the state is Off one cycle later.
- R2: When `supply_ok` is high in Off, the next cycle is Probe (`pwr_state`=1) with `det_req`=1, far inside the 6 ms startup bound.
- R3: In Probe, a cycle with `det_done`=1 moves the block to Active (4) if `det_found`=1, or to No-link saving (2) if `det_found`=0.
- R4: In No-link saving, a new probe (state 1) starts after RETRY_MS milliseconds: between (RETRY_MS-1) and RETRY_MS millisecond periods after entry.
- R5: In Active, exactly the selected port's `drv_en` bit is 1, `term_ok`=1 and `det_req`=0.
- R6: In Active, continuous idle (`sig_ap`=`sig_con`=0) lasting between (IDLE_MS-1) and IDLE_MS millisecond periods moves the block to Idle saving (3). There `term_ok` stays 1 and `drv_en` is 0.
- R7: Any cycle with `sig_ap` or `sig_con` high in Active restarts the idle wait. Idle gaps each shorter than one wait never cause Idle saving.
- R8: In Idle saving, a cycle with `sig_ap` or `sig_con` high returns the block to Active on the next cycle, far inside the 115 µs wake bound.
- R9: A change of `port_sel` in any powered state gives Probe (1) with `det_req`=1 on the next cycle.
- R10: `port_sel`=1 selects port 1 (bit 0 of `drv_en`/`park`) and `port_sel`=0 selects port 2 (bit 1). In every powered state the unselected port's `park` bit is 1, the selected port's is 0, and `sq_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply within range |
| port_sel | input | 1 | 1 = port 1, 0 = port 2 (unconnected reads as 0) |
| sig_ap | input | 1 | Signal present on the processor-side input |
| sig_con | input | 1 | Signal present on the connector-side input |
| det_done | input | 1 | Termination probe finished this cycle |
| det_found | input | 1 | Probe result: far-end receiver present |
| pwr_state | output | 3 | 0 Off, 1 Probe, 2 No-link saving, 3 Idle saving, 4 Active |
| drv_en | output | 2 | Line driver and equalizer enable per port |
| park | output | 2 | Park the port with a weak pull-up termination |
| sq_en | output | 1 | Keep signal-present and probe circuits alive |
| det_req | output | 1 | Request a termination probe |
| term_ok | output | 1 | Far-end termination reported present |

## Verification
The bench powers up with both select values and both probe results, so all four paths through Probe are covered. In each path it checks the complete output set against a table of expected outputs per state. The idle wait and the retry interval are measured in cycles against windows derived from the prescaler ratios. This separates a timer that runs too fast or too slow from one that is off by a single tick. Periodic signal pulses spaced below one wait show whether the idle timer restarts on activity. Select flips made in Active and in Idle saving, and supply loss made in Active, check that both re-probing and the shutdown take priority over the normal transitions.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [2:0] {
    LPS_OFF    = 3'd0,
    LPS_DETECT = 3'd1,
    LPS_NOCONN = 3'd2,
    LPS_IDLE   = 3'd3,
    LPS_ACTIVE = 3'd4
  } lps_state_e;
endpackage

// File: rtl/lps_tick_gen.sv
module lps_tick_gen #(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_tick
);
  localparam int UW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int MW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [UW-1:0] U_LAST = UW'(CYC_PER_US - 1);
  localparam logic [MW-1:0] M_LAST = MW'(US_PER_MS - 1);

  logic [UW-1:0] us_cnt;
  logic [MW-1:0] ms_pre;
  logic          us_tick;

  assign us_tick = (us_cnt == U_LAST);
  assign ms_tick = us_tick && (ms_pre == M_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt <= '0;
      ms_pre <= '0;
    end else begin
      us_cnt <= us_tick ? '0 : us_cnt + 1'b1;
      if (us_tick) ms_pre <= (ms_pre == M_LAST) ? '0 : ms_pre + 1'b1;
    end
  end
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
#(
  parameter int IDLE_MS  = 300,
  parameter int RETRY_MS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       port_sel,
  input  logic       sig_any,
  input  logic       ms_tick,
  input  logic       det_done,
  input  logic       det_found,
  output lps_state_e state,
  output logic       sel_cur
);
  localparam int TMAX = (IDLE_MS > RETRY_MS) ? IDLE_MS : RETRY_MS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] IDLE_LAST  = TW'(IDLE_MS - 1);
  localparam logic [TW-1:0] RETRY_LAST = TW'(RETRY_MS - 1);

  lps_state_e    nxt;
  logic [TW-1:0] tmr;
  logic          tmr_clr;

  always_comb begin
    nxt     = state;
    tmr_clr = 1'b0;
    if (!supply_ok)              nxt = LPS_OFF;
    else if (state == LPS_OFF)   nxt = LPS_DETECT;
    else if (port_sel != sel_cur) nxt = LPS_DETECT;
    else begin
      case (state)
        LPS_DETECT: if (det_done) nxt = det_found ? LPS_ACTIVE : LPS_NOCONN;
        LPS_NOCONN: if (ms_tick && tmr == RETRY_LAST) nxt = LPS_DETECT;
        LPS_ACTIVE: begin
          if (sig_any) tmr_clr = 1'b1;
          else if (ms_tick && tmr == IDLE_LAST) nxt = LPS_IDLE;
        end
        LPS_IDLE:   if (sig_any) nxt = LPS_ACTIVE;
        default:    nxt = LPS_OFF;
      endcase
    end
    if (nxt != state) tmr_clr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LPS_OFF;
      sel_cur <= 1'b0;
      tmr     <= '0;
    end else begin
      state   <= nxt;
      sel_cur <= port_sel;
      if (tmr_clr)      tmr <= '0;
      else if (ms_tick) tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/lps_port_steer.sv
module lps_port_steer #(
  parameter int NPORT = 2
) (
  input  logic             sel,
  input  logic             powered,
  input  logic             datapath_on,
  output logic [NPORT-1:0] drv_en,
  output logic [NPORT-1:0] park
);
  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    localparam logic PICK = (gi == 0) ? 1'b1 : 1'b0;
    logic is_sel;
    assign is_sel     = (sel == PICK);
    assign drv_en[gi] = datapath_on && is_sel;
    assign park[gi]   = powered && !is_sel;
  end
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
  import lps_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int IDLE_MS    = 300,
  parameter int RETRY_MS   = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       port_sel,
  input  logic       sig_ap,
  input  logic       sig_con,
  input  logic       det_done,
  input  logic       det_found,
  output logic [2:0] pwr_state,
  output logic [1:0] drv_en,
  output logic [1:0] park,
  output logic       sq_en,
  output logic       det_req,
  output logic       term_ok
);
  lps_state_e state;
  logic       sel_cur;
  logic       ms_tick;
  logic       powered;

  lps_tick_gen #(.CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick)
  );

  lps_fsm #(.IDLE_MS(IDLE_MS), .RETRY_MS(RETRY_MS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .port_sel(port_sel),
    .sig_any(sig_ap | sig_con), .ms_tick(ms_tick), .det_done(det_done),
    .det_found(det_found), .state(state), .sel_cur(sel_cur)
  );

  assign powered = (state != LPS_OFF);

  lps_port_steer #(.NPORT(2)) u_steer (
    .sel(sel_cur), .powered(powered), .datapath_on(state == LPS_ACTIVE),
    .drv_en(drv_en), .park(park)
  );

  assign pwr_state = state;
  assign sq_en     = powered;
  assign det_req   = (state == LPS_DETECT);
  assign term_ok   = (state == LPS_ACTIVE) || (state == LPS_IDLE);
endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       port_sel,
  input logic       sig_ap,
  input logic       sig_con,
  input logic       sel_cur,
  input logic [2:0] pwr_state,
  input logic [1:0] drv_en,
  input logic [1:0] park,
  input logic       sq_en,
  input logic       det_req,
  input logic       term_ok
);
  // R1
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> pwr_state == 3'd0);
  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd0 |-> (drv_en == 2'b00 && park == 2'b00 && !sq_en && !det_req && !term_ok));
  // R5
  active_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd4 |-> ($countones(drv_en) == 1 && term_ok && !det_req));
  // R8
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3 && supply_ok && port_sel == sel_cur && (sig_ap || sig_con))
      |=> pwr_state == 3'd4);
  // R9
  reprobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && port_sel != sel_cur) |=> (pwr_state == 3'd1 && det_req));
  // R10
  park_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 3'd0 |-> ($countones(park) == 1 && (park & drv_en) == 2'b00 && sq_en));
endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .port_sel(port_sel),
  .sig_ap(sig_ap), .sig_con(sig_con), .sel_cur(sel_cur),
  .pwr_state(pwr_state), .drv_en(drv_en), .park(park), .sq_en(sq_en),
  .det_req(det_req), .term_ok(term_ok)
);

// File: tb/link_pwr_ctrl_bench.sv
module link_pwr_ctrl_bench;
  localparam int CPU   = 2;
  localparam int UPM   = 5;
  localparam int IDLE  = 6;
  localparam int RETRY = 3;
  localparam int MSC   = CPU * UPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, port_sel = 1'b0, sig_ap = 1'b0, sig_con = 1'b0;
  logic det_done = 1'b0, det_found = 1'b0;
  logic [2:0] pwr_state;
  logic [1:0] drv_en, park;
  logic sq_en, det_req, term_ok;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  link_pwr_ctrl #(.CYC_PER_US(CPU), .US_PER_MS(UPM), .IDLE_MS(IDLE), .RETRY_MS(RETRY))
  u_link_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .port_sel(port_sel),
    .sig_ap(sig_ap), .sig_con(sig_con), .det_done(det_done), .det_found(det_found),
    .pwr_state(pwr_state), .drv_en(drv_en), .park(park), .sq_en(sq_en),
    .det_req(det_req), .term_ok(term_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // expected {drv_en, park, sq_en, det_req, term_ok} for a state and select
  function automatic logic [6:0] exp_outs(input int st, input logic sel);
    logic [1:0] pick;
    pick = sel ? 2'b01 : 2'b10;
    if (st == 0) return 7'b0;
    return {(st == 4) ? pick : 2'b00, ~pick, 1'b1, st == 1, (st == 3) || (st == 4)};
  endfunction

  task automatic chk_all(input string tag, input int st, input logic sel);
    chk({tag, " state"}, int'(pwr_state), st);
    chk({tag, " outs"}, int'({drv_en, park, sq_en, det_req, term_ok}), int'(exp_outs(st, sel)));
  endtask

  task automatic wait_leave(input int from, output int n);
    n = 100000;
    for (int i = 1; i <= 2000; i++) begin
      @(negedge clk);
      if (int'(pwr_state) != from) begin n = i; break; end
    end
  endtask

  task automatic answer_probe(input logic found);
    det_done = 1'b1; det_found = found;
    @(negedge clk);
    det_done = 1'b0; det_found = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 no supply", 0, 1'b0);

    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 2; f++) begin
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R1 off", 0, 1'b0);
        port_sel = logic'(s);
        supply_ok = 1'b1;
        @(negedge clk);
        chk_all("R2 R10 probe", 1, logic'(s));
        answer_probe(logic'(f));
        chk_all("R3 result", f ? 4 : 2, logic'(s));
        if (f == 0) begin
          wait_leave(2, n);
          chk_win("R4 retry", n, (RETRY - 1) * MSC, RETRY * MSC + 2);
          chk_all("R4 reprobe", 1, logic'(s));
          answer_probe(1'b1);
          chk_all("R5 R10 active", 4, logic'(s));
        end
        wait_leave(4, n);
        chk_win("R6 idle wait", n, (IDLE - 1) * MSC, IDLE * MSC + 2);
        chk_all("R6 idle save", 3, logic'(s));
        if (f == 0) sig_con = 1'b1; else sig_ap = 1'b1;
        @(negedge clk);
        sig_con = 1'b0; sig_ap = 1'b0;
        chk_all("R8 wake", 4, logic'(s));
      end
    end

    // R7: pulses spaced under one wait keep Active
    begin
      bit stayed = 1'b1;
      for (int k = 0; k < 8; k++) begin
        repeat ((IDLE - 2) * MSC) begin
          @(negedge clk);
          if (pwr_state != 3'd4) stayed = 1'b0;
        end
        sig_ap = 1'b1;
        @(negedge clk);
        sig_ap = 1'b0;
      end
      chk("R7 idle restart", int'(stayed), 1);
      wait_leave(4, n);
      chk_win("R7 wait after last pulse", n, (IDLE - 1) * MSC, IDLE * MSC + 2);
    end

    // R9 from Idle saving (state 3), port_sel currently 1
    port_sel = 1'b0;
    sig_con = 1'b1;
    @(negedge clk);
    sig_con = 1'b0;
    chk_all("R9 flip in idle", 1, 1'b0);
    answer_probe(1'b1);
    chk_all("R10 port2 active", 4, 1'b0);
    // R9 from Active
    port_sel = 1'b1;
    @(negedge clk);
    chk_all("R9 flip in active", 1, 1'b1);
    answer_probe(1'b1);
    chk_all("R10 port1 active", 4, 1'b1);
    // R1 supply loss from Active
    supply_ok = 1'b0;
    @(negedge clk);
    chk_all("R1 supply loss", 0, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule